// File: doc/BRIEF.md
# Tree-Routed Job Load Balancer

This block evens out work across a rectangular mesh of processing nodes. Each node reports how many jobs wait in its local queue, whether its processor is disabled, whether its queue can take one more job, and the job word at the head of its queue. A fixed reduction tree spans the mesh. Each row forms a horizontal chain that runs toward the root column, and that column forms a vertical chain that runs toward the root node. At every node a maximum selector and a minimum selector pick the best of the node's own count and its children's results, and record which input won.

The root looks at the overall largest and smallest counts. When they differ by two or more and the chosen destination has room, the root sends one enable down the recorded maximum branches and another down the recorded minimum branches. The job word climbs from the source to the root and descends to the destination. A room (ready) signal climbs from the destination to the root. All of this is combinational, so one job moves per clock. The pop and push strobes and the delivered word are registered.

A disabled node takes no part in its own comparison. It still relays its children's results and any job that passes through it.

Top module: `lb_tree_balancer`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is raised, `src_pop`, `dst_push` and `push_data` are all zero.
- R2: The source is the unmasked node with the largest count. Node i is at row i / COLS and column i % COLS. Its count is `node_count[i*CNT_W +: CNT_W]`.
- R3: The destination is the unmasked node with the smallest count.
- R4: A transfer is issued only when the largest count minus the smallest count is at least 2. A difference of 1 or 0 gives no transfer.
- R5: One clock edge after the inputs are applied, a transfer shows as a one-cycle `src_pop[src]` and `dst_push[dst]`, with `push_data` equal to `node_job[src*JOB_W +: JOB_W]`. When there is no transfer, `push_data` is zero.
- R6: A node with `node_mask[i]`=1 is never a source or destination. Nodes whose tree path crosses it still take part.
- R7: There is no transfer when every node is masked, or when only one node is unmasked, because source and destination would then be the same node.
- R8: If the selected destination has `node_room`=0, there is no transfer in that cycle. No other destination is chosen in its place.
- R9: At most one `src_pop` bit and at most one `dst_push` bit are set in any cycle, and never the same node.
- R10: Ties are resolved at each tree node with the node's own count first, then its west, east, north and south children. Across the mesh this picks, among equal candidates, the earliest in this order: root-row node, its westward nodes, its eastward nodes; then the same for each row going north from the root; then each row going south.
- R11: A new decision is made every cycle from that cycle's inputs, so transfers may occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Balancer clock |
| rst | input | 1 | Synchronous active-high reset |
| node_count | input | ROWS*COLS*CNT_W | Registered job count of each node |
| node_mask | input | ROWS*COLS | 1 = node's processor disabled, excluded from selection |
| node_job | input | ROWS*COLS*JOB_W | Head job word of each node's queue |
| node_room | input | ROWS*COLS | 1 = node's queue can accept a job |
| src_pop | output | ROWS*COLS | One-hot pop strobe to the source node |
| dst_push | output | ROWS*COLS | One-hot push strobe to the destination node |
| push_data | output | JOB_W | Job word delivered to the destination |

## Verification
Masking and tie resolution can act in the same cycle. A masked relay node, such as the root, may hold a count equal to other candidates, and the winner then passes to the next node in the tie order, with the path still crossing the masked node. The bench provokes this directly by masking the root and a row node while several counts are equal. It also reaches such cycles in a long random run with frequent masks and narrow count ranges. Every cycle is judged against a reference model that ranks the nodes by the tie order and scans them flatly, rather than by walking the tree.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [2:0] {DIR_OWN, DIR_W, DIR_E, DIR_N, DIR_S} dir_e;

  // k-th node in leaf-to-root evaluation order
  function automatic int order_at(int k, int rows, int cols, int rr, int rc);
    int pos;
    int res;
    pos = 0;
    res = rr * cols + rc;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < rc; c++) begin
        if (pos == k) res = r * cols + c;
        pos++;
      end
      for (int c = cols - 1; c > rc; c--) begin
        if (pos == k) res = r * cols + c;
        pos++;
      end
    end
    for (int r = 0; r < rr; r++) begin
      if (pos == k) res = r * cols + rc;
      pos++;
    end
    for (int r = rows - 1; r > rr; r--) begin
      if (pos == k) res = r * cols + rc;
      pos++;
    end
    return res;
  endfunction

  function automatic logic has_child(int r, int c, int d, int rows, int cols, int rr, int rc);
    case (d)
      1:       return (c > 0) && (c <= rc);
      2:       return (c < cols - 1) && (c >= rc);
      3:       return (c == rc) && (r > 0) && (r <= rr);
      4:       return (c == rc) && (r < rows - 1) && (r >= rr);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int child_of(int i, dir_e d, int cols);
    case (d)
      DIR_W:   return i - 1;
      DIR_E:   return i + 1;
      DIR_N:   return i - cols;
      DIR_S:   return i + cols;
      default: return i;
    endcase
  endfunction

endpackage

// File: rtl/lb_reduce.sv
module lb_reduce import lb_pkg::*; #(
  parameter int ROWS     = 3,
  parameter int COLS     = 3,
  parameter int ROOT_ROW = 1,
  parameter int ROOT_COL = 1,
  parameter int CNT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ROWS*COLS*CNT_W-1:0] count,
  input  logic [ROWS*COLS-1:0]       mask,
  output dir_e                       max_dir [ROWS*COLS],
  output dir_e                       min_dir [ROWS*COLS],
  output logic [CNT_W-1:0]           max_cnt,
  output logic [CNT_W-1:0]           min_cnt,
  output logic                       max_v,
  output logic                       min_v
);
  localparam int N    = ROWS * COLS;
  localparam int ROOT = ROOT_ROW * COLS + ROOT_COL;

  logic [CNT_W-1:0] mx [N];
  logic [CNT_W-1:0] mn [N];
  logic             vx [N];
  logic             vn [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mx[i] = '0; mn[i] = '0; vx[i] = 1'b0; vn[i] = 1'b0;
      max_dir[i] = DIR_OWN; min_dir[i] = DIR_OWN;
    end
    for (int k = 0; k < N; k++) begin
      int i;
      i = order_at(k, ROWS, COLS, ROOT_ROW, ROOT_COL);
      mx[i] = count[i*CNT_W +: CNT_W];
      mn[i] = count[i*CNT_W +: CNT_W];
      vx[i] = !mask[i];
      vn[i] = !mask[i];
      for (int d = 1; d <= 4; d++) begin
        if (has_child(i / COLS, i % COLS, d, ROWS, COLS, ROOT_ROW, ROOT_COL)) begin
          int j;
          j = child_of(i, dir_e'(3'(d)), COLS);
          if (vx[j] && (!vx[i] || mx[j] > mx[i])) begin
            vx[i] = 1'b1; mx[i] = mx[j]; max_dir[i] = dir_e'(3'(d));
          end
          if (vn[j] && (!vn[i] || mn[j] < mn[i])) begin
            vn[i] = 1'b1; mn[i] = mn[j]; min_dir[i] = dir_e'(3'(d));
          end
        end
      end
    end
  end

  assign max_cnt = mx[ROOT];
  assign min_cnt = mn[ROOT];
  assign max_v   = vx[ROOT];
  assign min_v   = vn[ROOT];

  // R3: the minimum never exceeds the maximum at the root
  a_r3_extremes_ordered: assert property (@(posedge clk) disable iff (rst)
    (max_v && min_v) |-> (max_cnt >= min_cnt));
  // R7: both reductions see the same set of unmasked nodes
  a_r7_valid_pair: assert property (@(posedge clk) disable iff (rst)
    max_v == min_v);
endmodule

// File: rtl/lb_route.sv
module lb_route import lb_pkg::*; #(
  parameter int ROWS     = 3,
  parameter int COLS     = 3,
  parameter int ROOT_ROW = 1,
  parameter int ROOT_COL = 1,
  parameter int JOB_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dir_e                       max_dir [ROWS*COLS],
  input  dir_e                       min_dir [ROWS*COLS],
  input  logic                       cand,
  input  logic [ROWS*COLS*JOB_W-1:0] jobs,
  input  logic [ROWS*COLS-1:0]       room,
  output logic                       fire,
  output logic [ROWS*COLS-1:0]       src_sel,
  output logic [ROWS*COLS-1:0]       dst_sel,
  output logic [JOB_W-1:0]           job_out
);
  localparam int N    = ROWS * COLS;
  localparam int ROOT = ROOT_ROW * COLS + ROOT_COL;

  logic [JOB_W-1:0] up_job [N];
  logic             up_rdy [N];
  logic             sv     [N];
  logic             dv     [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      up_job[i] = '0; up_rdy[i] = 1'b0; sv[i] = 1'b0; dv[i] = 1'b0;
    end
    // upward: job along max branches, ready along min branches
    for (int k = 0; k < N; k++) begin
      int i;
      i = order_at(k, ROWS, COLS, ROOT_ROW, ROOT_COL);
      if (max_dir[i] == DIR_OWN) up_job[i] = jobs[i*JOB_W +: JOB_W];
      else                       up_job[i] = up_job[child_of(i, max_dir[i], COLS)];
      if (min_dir[i] == DIR_OWN) up_rdy[i] = room[i];
      else                       up_rdy[i] = up_rdy[child_of(i, min_dir[i], COLS)];
    end
    fire = cand && up_rdy[ROOT];
    sv[ROOT] = fire;
    dv[ROOT] = fire;
    // downward: valids follow the remembered branches
    for (int k = N - 1; k >= 0; k--) begin
      int i;
      i = order_at(k, ROWS, COLS, ROOT_ROW, ROOT_COL);
      if (sv[i] && max_dir[i] != DIR_OWN) sv[child_of(i, max_dir[i], COLS)] = 1'b1;
      if (dv[i] && min_dir[i] != DIR_OWN) dv[child_of(i, min_dir[i], COLS)] = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      src_sel[i] = sv[i] && (max_dir[i] == DIR_OWN);
      dst_sel[i] = dv[i] && (min_dir[i] == DIR_OWN);
    end
  end

  assign job_out = up_job[ROOT];

  a_r9_src_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(src_sel));
  a_r9_dst_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(dst_sel));
  // R5: a fired transfer always reaches exactly one source and one destination
  a_r5_ends_reached: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($countones(src_sel) == 1 && $countones(dst_sel) == 1));
endmodule

// File: rtl/lb_tree_balancer.sv
module lb_tree_balancer import lb_pkg::*; #(
  parameter int ROWS     = 3,
  parameter int COLS     = 3,
  parameter int ROOT_ROW = ROWS / 2,
  parameter int ROOT_COL = COLS / 2,
  parameter int CNT_W    = 4,
  parameter int JOB_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ROWS*COLS*CNT_W-1:0] node_count,
  input  logic [ROWS*COLS-1:0]       node_mask,
  input  logic [ROWS*COLS*JOB_W-1:0] node_job,
  input  logic [ROWS*COLS-1:0]       node_room,
  output logic [ROWS*COLS-1:0]       src_pop,
  output logic [ROWS*COLS-1:0]       dst_push,
  output logic [JOB_W-1:0]           push_data
);
  localparam int N = ROWS * COLS;

  dir_e             max_dir [N];
  dir_e             min_dir [N];
  logic [CNT_W-1:0] max_cnt, min_cnt;
  logic             max_v, min_v, cand, fire;
  logic [N-1:0]     src_sel, dst_sel;
  logic [JOB_W-1:0] job_c;

  lb_reduce #(.ROWS(ROWS), .COLS(COLS), .ROOT_ROW(ROOT_ROW), .ROOT_COL(ROOT_COL),
              .CNT_W(CNT_W)) u_reduce (
    .clk(clk), .rst(rst), .count(node_count), .mask(node_mask),
    .max_dir(max_dir), .min_dir(min_dir), .max_cnt(max_cnt), .min_cnt(min_cnt),
    .max_v(max_v), .min_v(min_v));

  assign cand = max_v && min_v && (max_cnt > min_cnt) && ((max_cnt - min_cnt) > CNT_W'(1));

  lb_route #(.ROWS(ROWS), .COLS(COLS), .ROOT_ROW(ROOT_ROW), .ROOT_COL(ROOT_COL),
             .JOB_W(JOB_W)) u_route (
    .clk(clk), .rst(rst), .max_dir(max_dir), .min_dir(min_dir), .cand(cand),
    .jobs(node_job), .room(node_room), .fire(fire), .src_sel(src_sel),
    .dst_sel(dst_sel), .job_out(job_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_pop   <= '0;
      dst_push  <= '0;
      push_data <= '0;
    end else begin
      src_pop   <= src_sel;
      dst_push  <= dst_sel;
      push_data <= fire ? job_c : '0;
    end
  end

  // R6: masked nodes are never endpoints
  a_r6_no_masked_ends: assert property (@(posedge clk) disable iff (rst)
    ((src_sel | dst_sel) & node_mask) == '0);
  // R8: a push only goes to a node with room
  a_r8_dst_room: assert property (@(posedge clk) disable iff (rst)
    (|dst_sel) |-> (|(dst_sel & node_room)));
  // R4: the root only fires on a gap of two or more
  a_r4_gap_ok: assert property (@(posedge clk) disable iff (rst)
    fire |-> (max_cnt >= min_cnt + CNT_W'(2)) && (min_cnt < max_cnt));
  a_r9_disjoint: assert property (@(posedge clk) disable iff (rst)
    (src_pop & dst_push) == '0);
  // R5: pop and push strobes appear together
  a_r5_paired: assert property (@(posedge clk) disable iff (rst)
    $countones(src_pop) == $countones(dst_push));
endmodule

// File: tb/tb_lb_tree_balancer.sv
module tb_lb_tree_balancer;
  localparam int ROWS = 3, COLS = 3, RR = 1, RC = 1, CW = 4, JW = 32;
  localparam int N = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*CW-1:0] node_count = '0;
  logic [N-1:0]    node_mask = '0;
  logic [N*JW-1:0] node_job = '0;
  logic [N-1:0]    node_room = '1;
  logic [N-1:0]    src_pop, dst_push;
  logic [JW-1:0]   push_data;

  int checks = 0;
  int failures = 0;
  int rank_list [N];
  bit done = 1'b0;

  always #4 clk = ~clk;

  lb_tree_balancer #(.ROWS(ROWS), .COLS(COLS), .ROOT_ROW(RR), .ROOT_COL(RC),
                     .CNT_W(CW), .JOB_W(JW)) dut (
    .clk(clk), .rst(rst), .node_count(node_count), .node_mask(node_mask),
    .node_job(node_job), .node_room(node_room), .src_pop(src_pop),
    .dst_push(dst_push), .push_data(push_data));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // flat reference: scan nodes in tie-rank order, strict improvement wins
  task automatic model(output logic [N-1:0] ep, output logic [N-1:0] ed, output logic [JW-1:0] ej);
    int hi, lo, hc, lc;
    hi = -1; lo = -1; hc = 0; lc = 0;
    for (int k = 0; k < N; k++) begin
      int i, v;
      i = rank_list[k];
      v = int'(node_count[i*CW +: CW]);
      if (!node_mask[i]) begin
        if (hi < 0 || v > hc) begin hi = i; hc = v; end
        if (lo < 0 || v < lc) begin lo = i; lc = v; end
      end
    end
    ep = '0; ed = '0; ej = '0;
    if (hi >= 0 && lo >= 0 && hi != lo && hc - lc >= 2 && node_room[lo]) begin
      ep[hi] = 1'b1; ed[lo] = 1'b1; ej = node_job[hi*JW +: JW];
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0]  ep, ed;
    logic [JW-1:0] ej;
    model(ep, ed, ej);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "src_pop", 32'(src_pop), 32'(ep));
    chk(tag, "dst_push", 32'(dst_push), 32'(ed));
    chk(tag, "push_data", push_data, ej);
    chk("R9", "pop/push overlap", 32'(src_pop & dst_push), 32'd0);
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < N; i++) node_count[i*CW +: CW] = CW'(v);
  endtask

  task automatic set_cnt(int i, int v);
    node_count[i*CW +: CW] = CW'(v);
  endtask

  initial begin
    int p;
    p = 0;
    for (int r = RR; r >= 0; r--) begin
      rank_list[p++] = r * COLS + RC;
      for (int c = RC - 1; c >= 0; c--) rank_list[p++] = r * COLS + c;
      for (int c = RC + 1; c < COLS; c++) rank_list[p++] = r * COLS + c;
    end
    for (int r = RR + 1; r < ROWS; r++) begin
      rank_list[p++] = r * COLS + RC;
      for (int c = RC - 1; c >= 0; c--) rank_list[p++] = r * COLS + c;
      for (int c = RC + 1; c < COLS; c++) rank_list[p++] = r * COLS + c;
    end
    for (int i = 0; i < N; i++) node_job[i*JW +: JW] = 32'hA500_0000 + 32'(i * 17);

    // R1: reset holds outputs at zero even with a large imbalance present
    set_all(5); set_cnt(0, 15); set_cnt(8, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "src_pop", 32'(src_pop), 0);
    chk("R1", "dst_push", 32'(dst_push), 0);
    chk("R1", "push_data", push_data, 0);
    rst = 1'b0;

    // R4: gap of one gives nothing, gap of two moves a job
    set_all(5); set_cnt(0, 6);
    step("R4");
    chk("R4", "gap1 src_pop", 32'(src_pop), 0);
    set_cnt(0, 7);
    step("R4");
    chk("R4", "gap2 src_pop", 32'(src_pop), 32'h001);
    chk("R4", "gap2 dst_push", 32'(dst_push), 32'h010);

    // R10: ties go to root, then root-row west node when root is masked
    set_all(8); set_cnt(6, 0);
    step("R10");
    chk("R10", "root wins tie", 32'(src_pop), 32'h010);
    node_mask = 9'b000010000;
    step("R10");
    chk("R10", "west of root wins tie", 32'(src_pop), 32'h008);

    // R6: masked high node and masked root are relays only
    set_all(6); set_cnt(3, 15); set_cnt(0, 12); set_cnt(8, 1);
    node_mask = 9'b000011000;
    step("R6");
    chk("R6", "src through masked", 32'(src_pop), 32'h001);
    chk("R6", "dst", 32'(dst_push), 32'h100);

    // R7: all masked, then a single unmasked node
    node_mask = '1;
    step("R7");
    chk("R7", "all masked", 32'(src_pop | dst_push), 0);
    node_mask = 9'b111011111;
    step("R7");
    chk("R7", "single node", 32'(src_pop | dst_push), 0);
    node_mask = '0;

    // R8: destination without room blocks the move, no retarget
    set_all(5); set_cnt(0, 7); set_cnt(4, 3);
    node_room = 9'b111101111;
    step("R8");
    chk("R8", "no room", 32'(dst_push), 0);
    node_room = '1;

    // R11: two different transfers on consecutive cycles
    set_all(4); set_cnt(2, 9); set_cnt(6, 1);
    step("R11");
    chk("R11", "first", 32'(src_pop), 32'h004);
    set_all(4); set_cnt(7, 10); set_cnt(1, 0);
    step("R11");
    chk("R11", "second", 32'(dst_push), 32'h002);

    // R2 R3 R5 R9 R10: random patterns compared each clock
    for (int t = 0; t < 3000; t++) begin
      int span;
      span = (t % 3 == 0) ? 4 : 16;
      for (int i = 0; i < N; i++) begin
        set_cnt(i, int'($urandom % span));
        node_mask[i] = ($urandom % 6) == 0;
        node_room[i] = ($urandom % 8) != 0;
        node_job[i*JW +: JW] = $urandom;
      end
      step("R2 R3 R5 R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule